// File: doc/BRIEF.md
# Bus Transaction Security Filter

This block sits between bus initiators and a set of peripheral and on-chip memory targets, and decides for every transaction whether it may pass. A request names either a peripheral by index or a memory location by address. It also carries the security state of the initiator, a flag that marks the companion microcontroller as the initiator, and the direction of the access. The rules come from a two-bit attribute per peripheral and a page-count size per memory zone. A register block elsewhere supplies both. The filter does not program them.

The decision is registered. One cycle after a request is presented, the filter returns a response. A granted transaction is forwarded to the target, together with its direction and target. A blocked one never reaches the target. Instead it raises an error response and a single-cycle violation pulse that carries the offending index or address.

Memory is divided into equal contiguous zones starting at address zero. Each zone has a secure lower part, whose length is the programmed number of 4 KiB pages, and a non-secure upper part that runs to the top of the zone.

Top module: `sec_txn_filter`

## Requirements
- R1: Each request cycle (reqValid high) produces exactly one response cycle (rspValid high) on the following clock cycle. A cycle without a request produces no response on the next cycle.
- R2: A peripheral with attribute code 0 (secure-only) is granted only to secure initiators, for reads and for writes.
- R3: A peripheral with attribute code 1 (public read) grants reads from any initiator, but grants writes only to secure initiators.
- R4: A peripheral with attribute code 2 (coprocessor-reserved) is granted only when reqCoproc is high. Application-processor accesses are blocked, even when they are secure.
- R5: A peripheral with attribute code 3 (open) grants every access.
- R6: A peripheral index equal to or above PER_COUNT is blocked, whatever the attributes.
- R7: Within zone i, a non-secure access whose page offset ((addr - base) >> 12) is below that zone's programmed size is blocked. Any other non-secure access in the zone is granted. Secure accesses are granted anywhere in a zone.
- R8: A zone size of 0 makes the whole zone non-secure. A size equal to or above ZONE_PAGES makes the whole zone secure.
- R9: A memory address at or above ZONE_COUNT × ZONE_PAGES × 4096 is blocked.
- R10: A blocked request sets rspErr and violValid for one cycle, keeps fwdValid low, and presents its target on violInfo. A granted request sets fwdValid, keeps rspErr low, and presents its target on fwdTarget and its direction on fwdWrite. The target is the address for memory, or the zero-extended peripheral index.
- R11: While rstN is low, and in the first cycle after it rises, all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request presented this cycle |
| reqIsMem | input | 1 | 1 = memory request, 0 = peripheral request |
| reqPerIdx | input | IDX_W | Peripheral index |
| reqAddr | input | ADDR_W | Memory byte address |
| reqSecure | input | 1 | Initiator is in the secure state |
| reqCoproc | input | 1 | Initiator is the companion microcontroller |
| reqWrite | input | 1 | 1 = write, 0 = read |
| attrVec | input | 2*PER_COUNT | Attribute code of peripheral n at bits [2n+1:2n] |
| zoneSize | input | ZONE_COUNT*SIZE_W | Secure page count of zone i at bits [i*SIZE_W +: SIZE_W] |
| rspValid | output | 1 | Response cycle |
| rspErr | output | 1 | Error response (blocked) |
| fwdValid | output | 1 | Transaction forwarded to the target |
| fwdWrite | output | 1 | Direction of the forwarded transaction |
| fwdTarget | output | ADDR_W | Target of the forwarded transaction |
| violValid | output | 1 | Single-cycle violation pulse |
| violIsMem | output | 1 | Violation concerns memory (1) or a peripheral (0) |
| violInfo | output | ADDR_W | Offending address or index |

## Verification
The properties check the following on every cycle:
- the one-cycle request-to-response timing;
- that a response is either a forward or an error, never both;
- the blocking of out-of-range indices and of addresses past the last zone;
- the fixed outcomes of the secure-only and open attributes;
- that a memory target is carried to the response.

The per-attribute direction rules, the coprocessor reservation and the page-boundary split can only be shown by the directed scenarios. The same holds for the empty and full zone sizes. Those scenarios probe each side of every boundary, such as the last secure page against the first non-secure page, and the last valid index against the first invalid one.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

  typedef enum logic [1:0] {
    ATTR_SEC_ONLY = 2'd0,
    ATTR_PUB_READ = 2'd1,
    ATTR_COPROC   = 2'd2,
    ATTR_OPEN     = 2'd3
  } attr_e;

  typedef struct packed {
    logic take;   // a request is present
    logic grant;  // forward it
    logic deny;   // block it
  } strobe_t;

endpackage

// File: rtl/sf_decide.sv
module sf_decide
  import sec_filter_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int IDX_W      = 5,
  parameter int PER_COUNT  = 20,
  parameter int ZONE_COUNT = 2,
  parameter int ZONE_PAGES = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = $clog2(ZONE_PAGES + 1)
) (
  input  logic                         reqValid,
  input  logic                         reqIsMem,
  input  logic [IDX_W-1:0]             reqPerIdx,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic                         reqSecure,
  input  logic                         reqCoproc,
  input  logic                         reqWrite,
  input  logic [2*PER_COUNT-1:0]       attrVec,
  input  logic [ZONE_COUNT*SIZE_W-1:0] zoneSize,
  output strobe_t                      strobe
);

  localparam int ZONE_SPAN = ZONE_PAGES << PAGE_SHIFT;
  localparam logic [IDX_W:0] PER_LIMIT = (IDX_W + 1)'(PER_COUNT);

  logic [ZONE_COUNT-1:0] zoneHit;
  logic [ZONE_COUNT-1:0] zoneSecHit;

  for (genvar gi = 0; gi < ZONE_COUNT; gi++) begin : g_zone
    localparam logic [ADDR_W:0] ZBASE = (ADDR_W + 1)'(gi * ZONE_SPAN);
    localparam logic [ADDR_W:0] ZTOP  = (ADDR_W + 1)'((gi + 1) * ZONE_SPAN);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] pageOff;
    logic [SIZE_W-1:0] sizeSel;

    assign offset  = reqAddr - ZBASE[ADDR_W-1:0];
    assign pageOff = offset >> PAGE_SHIFT;
    assign sizeSel = zoneSize[gi*SIZE_W +: SIZE_W];
    assign zoneHit[gi] = ({1'b0, reqAddr} >= ZBASE) && ({1'b0, reqAddr} < ZTOP);
    assign zoneSecHit[gi] = zoneHit[gi] && (pageOff < ADDR_W'(sizeSel));
  end

  logic             perInRange;
  logic [IDX_W-1:0] safeIdx;
  attr_e            attrSel;
  logic             perGrant;
  logic             memGrant;
  logic             grantNow;

  always_comb begin
    perInRange = ({1'b0, reqPerIdx} < PER_LIMIT);
    safeIdx    = perInRange ? reqPerIdx : '0;
    attrSel    = attr_e'(attrVec[{safeIdx, 1'b0} +: 2]);
    unique case (attrSel)
      ATTR_SEC_ONLY: perGrant = reqSecure;
      ATTR_PUB_READ: perGrant = reqSecure || !reqWrite;
      ATTR_COPROC:   perGrant = reqCoproc;
      ATTR_OPEN:     perGrant = 1'b1;
      default:       perGrant = 1'b0;
    endcase
    memGrant = (|zoneHit) && (reqSecure || !(|zoneSecHit));
    grantNow = reqIsMem ? memGrant : (perInRange && perGrant);

    strobe.take  = reqValid;
    strobe.grant = reqValid && grantNow;
    strobe.deny  = reqValid && !grantNow;
  end

endmodule

// File: rtl/sf_capture.sv
module sf_capture
  import sec_filter_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              reqIsMem,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [IDX_W-1:0]  reqPerIdx,
  output logic              rspValid,
  output logic              rspErr,
  output logic              fwdValid,
  output logic              fwdWrite,
  output logic [ADDR_W-1:0] targetQ,
  output logic              violValid,
  output logic              violIsMem
);

  logic [ADDR_W-1:0] targetNow;
  assign targetNow = reqIsMem ? reqAddr : ADDR_W'(reqPerIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspErr    <= 1'b0;
      fwdValid  <= 1'b0;
      fwdWrite  <= 1'b0;
      violValid <= 1'b0;
      violIsMem <= 1'b0;
      targetQ   <= '0;
    end else begin
      rspValid  <= strobe.take;
      rspErr    <= strobe.deny;
      fwdValid  <= strobe.grant;
      fwdWrite  <= strobe.grant && reqWrite;
      violValid <= strobe.deny;
      violIsMem <= strobe.deny && reqIsMem;
      if (strobe.take) targetQ <= targetNow;
    end
  end

endmodule

// File: rtl/sec_txn_filter.sv
module sec_txn_filter
  import sec_filter_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int IDX_W      = 5,
  parameter int PER_COUNT  = 20,
  parameter int ZONE_COUNT = 2,
  parameter int ZONE_PAGES = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = $clog2(ZONE_PAGES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqIsMem,
  input  logic [IDX_W-1:0]             reqPerIdx,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic                         reqSecure,
  input  logic                         reqCoproc,
  input  logic                         reqWrite,
  input  logic [2*PER_COUNT-1:0]       attrVec,
  input  logic [ZONE_COUNT*SIZE_W-1:0] zoneSize,
  output logic                         rspValid,
  output logic                         rspErr,
  output logic                         fwdValid,
  output logic                         fwdWrite,
  output logic [ADDR_W-1:0]            fwdTarget,
  output logic                         violValid,
  output logic                         violIsMem,
  output logic [ADDR_W-1:0]            violInfo
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] targetQ;

  sf_decide #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PER_COUNT(PER_COUNT),
    .ZONE_COUNT(ZONE_COUNT), .ZONE_PAGES(ZONE_PAGES),
    .PAGE_SHIFT(PAGE_SHIFT), .SIZE_W(SIZE_W)
  ) u_decide (
    .reqValid(reqValid), .reqIsMem(reqIsMem), .reqPerIdx(reqPerIdx),
    .reqAddr(reqAddr), .reqSecure(reqSecure), .reqCoproc(reqCoproc),
    .reqWrite(reqWrite), .attrVec(attrVec), .zoneSize(zoneSize),
    .strobe(strobe)
  );

  sf_capture #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_capture (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIsMem(reqIsMem), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqPerIdx(reqPerIdx),
    .rspValid(rspValid), .rspErr(rspErr), .fwdValid(fwdValid),
    .fwdWrite(fwdWrite), .targetQ(targetQ),
    .violValid(violValid), .violIsMem(violIsMem)
  );

  assign fwdTarget = targetQ;
  assign violInfo  = targetQ;

endmodule

// File: rtl/sec_txn_filter_chk.sv
module sec_txn_filter_chk #(
  parameter int ADDR_W     = 20,
  parameter int IDX_W      = 5,
  parameter int PER_COUNT  = 20,
  parameter int ZONE_COUNT = 2,
  parameter int ZONE_PAGES = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqIsMem,
  input logic [IDX_W-1:0]       reqPerIdx,
  input logic [ADDR_W-1:0]      reqAddr,
  input logic                   reqSecure,
  input logic [2*PER_COUNT-1:0] attrVec,
  input logic                   rspValid,
  input logic                   rspErr,
  input logic                   fwdValid,
  input logic                   violValid,
  input logic [ADDR_W-1:0]      violInfo
);

  localparam logic [ADDR_W:0] MEM_END =
    (ADDR_W + 1)'(ZONE_COUNT * (ZONE_PAGES << PAGE_SHIFT));

  logic             inRange;
  logic [IDX_W-1:0] clampIdx;
  logic [1:0]       curAttr;
  logic             perReq;
  logic             memReq;

  assign inRange  = (int'(reqPerIdx) < PER_COUNT);
  assign clampIdx = inRange ? reqPerIdx : '0;
  assign curAttr  = attrVec[{clampIdx, 1'b0} +: 2];
  assign perReq   = reqValid && !reqIsMem;
  assign memReq   = reqValid && reqIsMem;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (fwdValid != rspErr)); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> violValid); // R10
  AST_SEC_ONLY_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && inRange && curAttr == 2'd0 && !reqSecure) |=> rspErr); // R2
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && inRange && curAttr == 2'd3) |=> fwdValid); // R5
  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && !inRange) |=> rspErr); // R6
  AST_MEM_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && ({1'b0, reqAddr} >= MEM_END)) |=> rspErr); // R9
  AST_MEM_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (violInfo == $past(reqAddr))); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !rspValid && !fwdValid && !violValid); // R11

endmodule

bind sec_txn_filter sec_txn_filter_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PER_COUNT(PER_COUNT),
  .ZONE_COUNT(ZONE_COUNT), .ZONE_PAGES(ZONE_PAGES), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsMem(reqIsMem),
  .reqPerIdx(reqPerIdx), .reqAddr(reqAddr), .reqSecure(reqSecure),
  .attrVec(attrVec), .rspValid(rspValid), .rspErr(rspErr),
  .fwdValid(fwdValid), .violValid(violValid), .violInfo(violInfo)
);

// File: tb/sec_txn_filter_tb.sv
module sec_txn_filter_tb;

  localparam int ADDR_W = 20;
  localparam int IDX_W  = 5;
  localparam int PER_COUNT = 20;
  localparam int ZONE_COUNT = 2;
  localparam int ZONE_PAGES = 16;
  localparam int SIZE_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqIsMem = 1'b0, reqSecure = 1'b0, reqCoproc = 1'b0, reqWrite = 1'b0;
  logic [IDX_W-1:0]  reqPerIdx = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2*PER_COUNT-1:0] attrVec;
  logic [ZONE_COUNT*SIZE_W-1:0] zoneSize = '0;
  logic rspValid, rspErr, fwdValid, fwdWrite, violValid, violIsMem;
  logic [ADDR_W-1:0] fwdTarget, violInfo;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sec_txn_filter #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PER_COUNT(PER_COUNT),
    .ZONE_COUNT(ZONE_COUNT), .ZONE_PAGES(ZONE_PAGES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsMem(reqIsMem),
    .reqPerIdx(reqPerIdx), .reqAddr(reqAddr), .reqSecure(reqSecure),
    .reqCoproc(reqCoproc), .reqWrite(reqWrite), .attrVec(attrVec),
    .zoneSize(zoneSize), .rspValid(rspValid), .rspErr(rspErr),
    .fwdValid(fwdValid), .fwdWrite(fwdWrite), .fwdTarget(fwdTarget),
    .violValid(violValid), .violIsMem(violIsMem), .violInfo(violInfo)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Flags packed as {rspValid, fwdValid, rspErr, violValid, fwdWrite, violIsMem}
  task automatic issue(input bit mem, input int idx, input int addr, input bit sec,
                       input bit cop, input bit wr, input bit expOk, input string tag);
    logic [5:0] expFlags;
    logic [ADDR_W-1:0] expTgt;
    @(negedge clk);
    reqValid = 1'b1; reqIsMem = mem; reqPerIdx = IDX_W'(idx); reqAddr = ADDR_W'(addr);
    reqSecure = sec; reqCoproc = cop; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    expFlags = {1'b1, expOk, !expOk, !expOk, expOk && wr, !expOk && mem};
    expTgt = mem ? ADDR_W'(addr) : ADDR_W'(idx);
    check({rspValid, fwdValid, rspErr, violValid, fwdWrite, violIsMem} == expFlags,
          {tag, " flags"}, 32'({rspValid, fwdValid, rspErr, violValid, fwdWrite, violIsMem}), 32'(expFlags));
    check((expOk ? fwdTarget : violInfo) == expTgt, {tag, " target"},
          32'(expOk ? fwdTarget : violInfo), 32'(expTgt));
  endtask

  task automatic t_reset();
    check({rspValid, fwdValid, rspErr, violValid} == 4'b0, "R11 outputs in reset",
          32'({rspValid, fwdValid, rspErr, violValid}), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check({rspValid, fwdValid, rspErr, violValid} == 4'b0, "R11 after release",
          32'({rspValid, fwdValid, rspErr, violValid}), 0);
  endtask

  task automatic t_secOnly();   // idx 0 holds code 0
    issue(0, 0, 0, 1, 0, 0, 1, "R2 secure read");
    issue(0, 0, 0, 1, 0, 1, 1, "R2 secure write");
    issue(0, 0, 0, 0, 0, 0, 0, "R2 nonsecure read");
    issue(0, 4, 0, 0, 0, 1, 0, "R2 nonsecure write");
  endtask

  task automatic t_pubRead();   // idx 1 holds code 1
    issue(0, 1, 0, 0, 0, 0, 1, "R3 nonsecure read");
    issue(0, 1, 0, 0, 0, 1, 0, "R3 nonsecure write");
    issue(0, 5, 0, 1, 0, 1, 1, "R3 secure write");
  endtask

  task automatic t_coproc();    // idx 2 holds code 2
    issue(0, 2, 0, 1, 0, 0, 0, "R4 secure app read");
    issue(0, 2, 0, 1, 0, 1, 0, "R4 secure app write");
    issue(0, 2, 0, 0, 1, 1, 1, "R4 coprocessor write");
  endtask

  task automatic t_open();      // idx 3 holds code 3
    issue(0, 3, 0, 0, 0, 1, 1, "R5 nonsecure write");
    issue(0, 3, 0, 0, 1, 0, 1, "R5 coprocessor read");
  endtask

  task automatic t_idxLimit();
    issue(0, 19, 0, 0, 0, 1, 1, "R6 last index");
    issue(0, 20, 0, 1, 0, 0, 0, "R6 first invalid index");
    issue(0, 31, 0, 1, 1, 0, 0, "R6 top index");
  endtask

  task automatic t_zoneSplit(); // zone0 size 4 pages
    zoneSize = {5'd0, 5'd4};
    issue(1, 0, 'h03FFC, 0, 0, 0, 0, "R7 last secure page nonsecure");
    issue(1, 0, 'h04000, 0, 0, 1, 1, "R7 first open page nonsecure");
    issue(1, 0, 'h00010, 1, 0, 1, 1, "R7 secure in secure part");
    issue(1, 0, 'h0F000, 1, 0, 0, 1, "R7 secure in open part");
  endtask

  task automatic t_zoneEdges();
    issue(1, 0, 'h10000, 0, 0, 1, 1, "R8 size zero zone base");
    zoneSize = {5'd16, 5'd4};
    issue(1, 0, 'h1FFF0, 0, 0, 0, 0, "R8 full size top page");
    issue(1, 0, 'h1FFF0, 1, 0, 1, 1, "R8 full size secure");
    zoneSize = {5'd31, 5'd0};
    issue(1, 0, 'h1F000, 0, 0, 0, 0, "R8 oversize zone");
    issue(1, 0, 'h00000, 0, 0, 1, 1, "R8 size zero zone0");
  endtask

  task automatic t_outside();
    issue(1, 0, 'h20000, 1, 0, 0, 0, "R9 first address past zones");
    issue(1, 0, 'hFFFFF, 1, 1, 1, 0, "R9 top address");
  endtask

  task automatic t_idle();
    issue(0, 3, 0, 0, 0, 0, 1, "R10 grant before idle");
    @(negedge clk);
    check({rspValid, fwdValid, rspErr, violValid} == 4'b0, "R1 idle cycle no response",
          32'({rspValid, fwdValid, rspErr, violValid}), 0);
  endtask

  initial begin
    for (int i = 0; i < PER_COUNT; i++) attrVec[2*i +: 2] = 2'(i % 4);
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_secOnly();
    t_pubRead();
    t_coproc();
    t_open();
    t_idxLimit();
    t_zoneSplit();
    t_zoneEdges();
    t_outside();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule